// File: doc/BRIEF.md
# Physical register wakeup scoreboard

This block sits beside an issue window and answers one question for every waiting slot: are both source operands available yet? It holds one ready bit for each tracked physical register, plus, for each window slot, two source tags and a ready flag per source. Rename announces a new producer for a tag with an allocate pulse, and that register's bit drops. Completing instructions broadcast their destination tags on several lanes at once, and each broadcast raises the register's bit and wakes every waiting slot source that carries the same tag.

An incoming instruction writes a slot with its two source tags and the readiness that rename saw. The block re-checks each source that is still pending against the scoreboard and against the broadcasts of the same cycle. This catches an operand that completed while the instruction was on its way. Tags at or above the tracked count, such as miscellaneous or control registers, never take part: they do not touch the ready bits, and a source that carries one never waits. If a new producer is assigned while a slot is still waiting on the old value of that tag, a sticky error bit is raised.

Top module: `wakeup_scoreboard`

## Requirements
- R1: The tracked register count is INT_REGS + FP_REGS, 32 by default. After reset every ready bit reads 0, no slot reports ready and `error` is 0.
- R2: A broadcast on any lane of `wake_valid`/`wake_tag` whose tag is below the tracked count sets that register's bit in `reg_ready`, visible from the next cycle. All lanes act in the same cycle.
- R3: An allocate with a tracked tag clears that register's bit from the next cycle. If an allocate and a broadcast name the same tag in one cycle, the bit ends cleared.
- R4: A tag at or above the tracked count leaves `reg_ready` unchanged on allocate and on broadcast, and an insert source that carries such a tag counts as ready.
- R5: On insert, a source is stored ready if its `ins_src_rdy` bit is 1, if its scoreboard bit is already set, or if a broadcast in the same cycle carries its tag. Otherwise it waits. Source s occupies bits [s*TAG_W +: TAG_W] of `ins_src_tag`.
- R6: A waiting source of a valid slot becomes ready the cycle after a broadcast on any lane carries its tag.
- R7: `entry_ready[i]` is 1 only while slot i is valid and both of its sources are ready. A release clears the slot from the next cycle, and an insert to the same slot in the same cycle wins over the release.
- R8: An allocate of a tracked tag sets `error` when a valid slot has a source with that tag that is not ready and is not woken in the same cycle. `error` then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | New producer announced this cycle |
| alloc_tag | input | TAG_W | Destination tag of the new producer |
| ins_valid | input | 1 | Write an instruction into a window slot |
| ins_idx | input | clog2(ENTRIES) | Slot written by the insert |
| ins_src_tag | input | 2*TAG_W | Two source tags, source 0 in the low bits |
| ins_src_rdy | input | 2 | Readiness of each source as seen by rename |
| wake_valid | input | WAKE_W | Broadcast lane valid bits |
| wake_tag | input | WAKE_W*TAG_W | Broadcast tags, lane 0 in the low bits |
| release_valid | input | 1 | Free a window slot |
| release_idx | input | clog2(ENTRIES) | Slot to free |
| reg_ready | output | INT_REGS+FP_REGS | Scoreboard ready bit per tracked register |
| entry_ready | output | ENTRIES | Slot valid with both sources ready |
| error | output | 1 | Sticky: producer reassigned while consumers waited |

## Verification
The assertions assume that `alloc_tag` and `wake_tag` are below 2^TAG_W and that the tracked count fits that range. They also assume that the same-cycle order between an allocate and a broadcast of one tag is the intended one: the allocate wins. The stimulus follows the rename contract by reallocating only tags whose consumers have been woken. The one deliberate exception is the cycle that checks the error flag. Out-of-range tags are driven only on the paths that must ignore them.

// File: rtl/sb_pkg.sv
package sb_pkg;
    // Source operands carried by each issue-window slot.
    localparam int SB_SRCS = 2;
endpackage

// File: rtl/sb_wake_match.sv
module sb_wake_match #(
    parameter int TAG_W = 6,
    parameter int LANES = 2,
    parameter int NREGS = 32
) (
    input  logic [TAG_W-1:0]       tag,
    input  logic [LANES-1:0]       lane_valid,
    input  logic [LANES*TAG_W-1:0] lane_tag,
    output logic                   hit
);
    localparam logic [TAG_W-1:0] LIMIT = TAG_W'(NREGS);

    always_comb begin
        hit = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            if (lane_valid[l] && (lane_tag[l*TAG_W +: TAG_W] == tag) && (tag < LIMIT))
                hit = 1'b1;
        end
    end
endmodule

// File: rtl/sb_ready_bits.sv
module sb_ready_bits #(
    parameter int TAG_W = 6,
    parameter int LANES = 2,
    parameter int NREGS = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_valid,
    input  logic [TAG_W-1:0]       alloc_tag,
    input  logic [LANES-1:0]       wake_valid,
    input  logic [LANES*TAG_W-1:0] wake_tag,
    output logic [NREGS-1:0]       ready_q
);
    localparam int               IDX_W = $clog2(NREGS);
    localparam logic [TAG_W-1:0] LIMIT = TAG_W'(NREGS);

    logic [NREGS-1:0] ready_d;
    logic             alloc_trk;

    assign alloc_trk = alloc_valid && (alloc_tag < LIMIT);

    always_comb begin
        ready_d = ready_q;
        for (int l = 0; l < LANES; l++) begin
            if (wake_valid[l] && (wake_tag[l*TAG_W +: TAG_W] < LIMIT))
                ready_d[wake_tag[l*TAG_W +: IDX_W]] = 1'b1;
        end
        // A new producer overrides a stale broadcast of the same tag.
        if (alloc_trk)
            ready_d[alloc_tag[IDX_W-1:0]] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ready_q <= '0;
        else        ready_q <= ready_d;
    end

    p_alloc_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid && (alloc_tag < LIMIT) |=> !ready_q[$past(alloc_tag[IDX_W-1:0])]);

    p_untracked_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid && !(alloc_tag < LIMIT) && (wake_valid == '0) |=> $stable(ready_q));

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        p_wake_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            wake_valid[l] && (wake_tag[l*TAG_W +: TAG_W] < LIMIT)
            && !(alloc_valid && alloc_tag == wake_tag[l*TAG_W +: TAG_W])
            |=> ready_q[$past(wake_tag[l*TAG_W +: IDX_W])]);
    end
endmodule

// File: rtl/wakeup_scoreboard.sv
module wakeup_scoreboard
    import sb_pkg::*;
#(
    parameter int INT_REGS = 16,
    parameter int FP_REGS  = 16,
    parameter int TAG_W    = 6,
    parameter int ENTRIES  = 4,
    parameter int WAKE_W   = 2,
    localparam int NREGS   = INT_REGS + FP_REGS,
    localparam int ENT_W   = $clog2(ENTRIES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_valid,
    input  logic [TAG_W-1:0]        alloc_tag,
    input  logic                    ins_valid,
    input  logic [ENT_W-1:0]        ins_idx,
    input  logic [2*TAG_W-1:0]      ins_src_tag,
    input  logic [1:0]              ins_src_rdy,
    input  logic [WAKE_W-1:0]       wake_valid,
    input  logic [WAKE_W*TAG_W-1:0] wake_tag,
    input  logic                    release_valid,
    input  logic [ENT_W-1:0]        release_idx,
    output logic [NREGS-1:0]        reg_ready,
    output logic [ENTRIES-1:0]      entry_ready,
    output logic                    error
);
    localparam int               IDX_W = $clog2(NREGS);
    localparam logic [TAG_W-1:0] LIMIT = TAG_W'(NREGS);

    typedef struct packed {
        logic [ENTRIES-1:0]                        vld;
        logic [ENTRIES-1:0][SB_SRCS-1:0]           rdy;
        logic [ENTRIES-1:0][SB_SRCS-1:0][TAG_W-1:0] tag;
        logic                                      err;
    } win_t;

    win_t st_d, st_q;

    logic [SB_SRCS-1:0][TAG_W-1:0]   ins_tag;
    logic [SB_SRCS-1:0]              ins_hit;
    logic [SB_SRCS-1:0]              ins_rdy_now;
    logic [ENTRIES-1:0][SB_SRCS-1:0] ent_hit;
    logic                            err_hit;
    logic                            alloc_trk;

    assign ins_tag   = ins_src_tag;
    assign alloc_trk = alloc_valid && (alloc_tag < LIMIT);

    sb_ready_bits #(.TAG_W(TAG_W), .LANES(WAKE_W), .NREGS(NREGS)) u_bits (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_tag(alloc_tag),
        .wake_valid(wake_valid), .wake_tag(wake_tag),
        .ready_q(reg_ready)
    );

    for (genvar s = 0; s < SB_SRCS; s++) begin : g_ins
        sb_wake_match #(.TAG_W(TAG_W), .LANES(WAKE_W), .NREGS(NREGS)) u_match (
            .tag(ins_tag[s]), .lane_valid(wake_valid), .lane_tag(wake_tag),
            .hit(ins_hit[s])
        );
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        for (genvar s = 0; s < SB_SRCS; s++) begin : g_src
            sb_wake_match #(.TAG_W(TAG_W), .LANES(WAKE_W), .NREGS(NREGS)) u_match (
                .tag(st_q.tag[e][s]), .lane_valid(wake_valid), .lane_tag(wake_tag),
                .hit(ent_hit[e][s])
            );
        end
    end

    // Insert-time readiness: rename flag, scoreboard re-check, same-cycle broadcast.
    always_comb begin
        for (int s = 0; s < SB_SRCS; s++) begin
            if (ins_tag[s] < LIMIT)
                ins_rdy_now[s] = ins_src_rdy[s] | reg_ready[ins_tag[s][IDX_W-1:0]] | ins_hit[s];
            else
                ins_rdy_now[s] = 1'b1;
        end
    end

    always_comb begin
        st_d    = st_q;
        err_hit = 1'b0;
        for (int e = 0; e < ENTRIES; e++) begin
            for (int s = 0; s < SB_SRCS; s++) begin
                if (ent_hit[e][s])
                    st_d.rdy[e][s] = 1'b1;
                if (alloc_trk && st_q.vld[e] && !st_q.rdy[e][s] && !ent_hit[e][s]
                    && (st_q.tag[e][s] == alloc_tag))
                    err_hit = 1'b1;
            end
        end
        if (release_valid)
            st_d.vld[release_idx] = 1'b0;
        if (ins_valid) begin
            st_d.vld[ins_idx] = 1'b1;
            for (int s = 0; s < SB_SRCS; s++) begin
                st_d.tag[ins_idx][s] = ins_tag[s];
                st_d.rdy[ins_idx][s] = ins_rdy_now[s];
            end
        end
        if (err_hit)
            st_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int e = 0; e < ENTRIES; e++)
            entry_ready[e] = st_q.vld[e] & (&st_q.rdy[e]);
    end
    assign error = st_q.err;

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);

    p_release_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        release_valid && !(ins_valid && ins_idx == release_idx)
        |=> !entry_ready[$past(release_idx)]);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_chk
        for (genvar s = 0; s < SB_SRCS; s++) begin : g_src_chk
            p_wake_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.vld[e] && ent_hit[e][s] && !(ins_valid && ins_idx == ENT_W'(e))
                |=> st_q.rdy[e][s]);
        end
    end
endmodule

// File: tb/wakeup_scoreboard_bench.sv
module wakeup_scoreboard_bench;
    localparam int TAG_W = 6;
    localparam int ENT   = 4;
    localparam int NREGS = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_valid = 1'b0;
    logic [TAG_W-1:0]  alloc_tag = '0;
    logic              ins_valid = 1'b0;
    logic [1:0]        ins_idx = '0;
    logic [2*TAG_W-1:0] ins_src_tag = '0;
    logic [1:0]        ins_src_rdy = '0;
    logic [1:0]        wake_valid = '0;
    logic [2*TAG_W-1:0] wake_tag = '0;
    logic              release_valid = 1'b0;
    logic [1:0]        release_idx = '0;
    logic [NREGS-1:0]  reg_ready;
    logic [ENT-1:0]    entry_ready;
    logic              error;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    wakeup_scoreboard u_wakeup_scoreboard (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_tag(alloc_tag),
        .ins_valid(ins_valid), .ins_idx(ins_idx),
        .ins_src_tag(ins_src_tag), .ins_src_rdy(ins_src_rdy),
        .wake_valid(wake_valid), .wake_tag(wake_tag),
        .release_valid(release_valid), .release_idx(release_idx),
        .reg_ready(reg_ready), .entry_ready(entry_ready), .error(error)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       al_v;  logic [5:0] al_t;
        logic       w0_v;  logic [5:0] w0_t;
        logic       w1_v;  logic [5:0] w1_t;
        logic       in_v;  logic [1:0] in_i;
        logic [5:0] s0_t;  logic       s0_r;
        logic [5:0] s1_t;  logic       s1_r;
        logic       rl_v;  logic [1:0] rl_i;
        logic [3:0] ex_rdy; logic      ex_err;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        // R3: allocate tag 5, nothing waits on it
        '{4'd3, 1'b1,6'd5,  1'b0,6'd0,  1'b0,6'd0,  1'b0,2'd0, 6'd0,1'b0, 6'd0,1'b0,  1'b0,2'd0, 4'b0000,1'b0},
        // R4: slot 0 waits on 5; source 1 tag 40 is untracked so ready
        '{4'd4, 1'b0,6'd0,  1'b0,6'd0,  1'b0,6'd0,  1'b1,2'd0, 6'd5,1'b0, 6'd40,1'b0, 1'b0,2'd0, 4'b0000,1'b0},
        // R6: lane 1 broadcasts 5, slot 0 wakes
        '{4'd6, 1'b0,6'd0,  1'b0,6'd0,  1'b1,6'd5,  1'b0,2'd0, 6'd0,1'b0, 6'd0,1'b0,  1'b0,2'd0, 4'b0001,1'b0},
        // R5: slot 1 source 1 tag 5 found ready in scoreboard, source 0 tag 7 waits
        '{4'd5, 1'b0,6'd0,  1'b0,6'd0,  1'b0,6'd0,  1'b1,2'd1, 6'd7,1'b0, 6'd5,1'b0,  1'b0,2'd0, 4'b0001,1'b0},
        // R5: insert of tag 9 meets same-cycle broadcast; R2 two lanes wake 9 and 7
        '{4'd5, 1'b0,6'd0,  1'b1,6'd9,  1'b1,6'd7,  1'b1,2'd2, 6'd9,1'b0, 6'd9,1'b0,  1'b0,2'd0, 4'b0111,1'b0},
        // R7: release slot 0
        '{4'd7, 1'b0,6'd0,  1'b0,6'd0,  1'b0,6'd0,  1'b0,2'd0, 6'd0,1'b0, 6'd0,1'b0,  1'b1,2'd0, 4'b0110,1'b0},
        // R7: slot 3 waits on 11, source 0 flagged ready by rename
        '{4'd7, 1'b0,6'd0,  1'b0,6'd0,  1'b0,6'd0,  1'b1,2'd3, 6'd3,1'b1, 6'd11,1'b0, 1'b0,2'd0, 4'b0110,1'b0},
        // R8: allocate 11 while slot 3 still waits on it
        '{4'd8, 1'b1,6'd11, 1'b0,6'd0,  1'b0,6'd0,  1'b0,2'd0, 6'd0,1'b0, 6'd0,1'b0,  1'b0,2'd0, 4'b0110,1'b1},
        // R6: broadcast 11 wakes slot 3, error stays
        '{4'd6, 1'b0,6'd0,  1'b1,6'd11, 1'b0,6'd0,  1'b0,2'd0, 6'd0,1'b0, 6'd0,1'b0,  1'b0,2'd0, 4'b1110,1'b1},
        // R7: insert waiting slot 0, release slot 1
        '{4'd7, 1'b0,6'd0,  1'b0,6'd0,  1'b0,6'd0,  1'b1,2'd0, 6'd12,1'b0, 6'd12,1'b0, 1'b1,2'd1, 4'b1100,1'b1}
    };

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic idle();
        alloc_valid = 1'b0; ins_valid = 1'b0; wake_valid = '0; release_valid = 1'b0;
        ins_src_rdy = '0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 reg_ready", 64'(reg_ready), 64'd0);
        chk("R1 entry_ready", 64'(entry_ready), 64'd0);
        chk("R1 error", 64'(error), 64'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            alloc_valid = VECS[i].al_v; alloc_tag = VECS[i].al_t;
            wake_valid  = {VECS[i].w1_v, VECS[i].w0_v};
            wake_tag    = {VECS[i].w1_t, VECS[i].w0_t};
            ins_valid   = VECS[i].in_v; ins_idx = VECS[i].in_i;
            ins_src_tag = {VECS[i].s1_t, VECS[i].s0_t};
            ins_src_rdy = {VECS[i].s1_r, VECS[i].s0_r};
            release_valid = VECS[i].rl_v; release_idx = VECS[i].rl_i;
            step();
            chk($sformatf("R%0d vec%0d entry_ready", VECS[i].req, i), 64'(entry_ready), 64'(VECS[i].ex_rdy));
            chk($sformatf("R8 vec%0d error", i), 64'(error), 64'(VECS[i].ex_err));
        end

        do_reset();
        chk("R1 error cleared by reset", 64'(error), 64'd0);
        chk("R1 slots cleared by reset", 64'(entry_ready), 64'd0);

        // R4: untracked tags on broadcast and allocate change nothing
        @(negedge clk);
        wake_valid = 2'b01; wake_tag = {6'd0, 6'd33};
        alloc_valid = 1'b1; alloc_tag = 6'd40;
        step();
        chk("R4 untracked tags", 64'(reg_ready), 64'd0);

        // R2: both lanes in one cycle, highest and lowest tracked tag
        @(negedge clk);
        wake_valid = 2'b11; wake_tag = {6'd0, 6'd31};
        step();
        chk("R2 two lanes", 64'(reg_ready), 64'h0000_0000_8000_0001);

        // R3: allocate beats same-cycle broadcast
        @(negedge clk);
        alloc_valid = 1'b1; alloc_tag = 6'd31;
        wake_valid = 2'b01; wake_tag = {6'd0, 6'd31};
        step();
        chk("R3 alloc wins", 64'(reg_ready), 64'd1);

        // R5: source 1 tag 0 picked up from scoreboard, source 0 tag 11 waits
        @(negedge clk);
        ins_valid = 1'b1; ins_idx = 2'd0; ins_src_tag = {6'd0, 6'd11};
        step();
        chk("R5 scoreboard recheck", 64'(entry_ready), 64'd0);

        // R8: consumer woken in the same cycle as reallocation is no error
        @(negedge clk);
        alloc_valid = 1'b1; alloc_tag = 6'd11;
        wake_valid = 2'b10; wake_tag = {6'd11, 6'd0};
        step();
        chk("R8 no error when woken", 64'(error), 64'd0);
        chk("R6 woken slot", 64'(entry_ready), 64'd1);
        chk("R3 bit 11 stays clear", 64'(reg_ready), 64'd1);

        // R3: plain allocate clears, R8 nothing waits so no error
        @(negedge clk);
        alloc_valid = 1'b1; alloc_tag = 6'd0;
        step();
        chk("R3 alloc clears", 64'(reg_ready), 64'd0);
        chk("R8 no waiter", 64'(error), 64'd0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule